// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block drives a single-data-rate synchronous DRAM with a 16-bit data bus and four internal banks. It serves a simple request port on which a client asks for one 16-bit read or write at a bank/row/column address. A write carries its data and a two-bit byte mask. The controller brings the memory up after reset and then turns every request into the right mix of activate, read/write and precharge commands. It keeps track of the open row in each bank, and it inserts auto refreshes at a rate set from the clock frequency.

Requests use a valid/ready handshake. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the client must hold every request field unchanged. `req_ready` is high only when all of the following are true: the controller is idle, no refresh is owed, and the addressed row is already open. When the row is not open, the controller opens it first and raises `req_ready` a few cycles later. Read data comes back as a one-cycle `rd_valid` pulse with no back-pressure, in the order the reads were accepted.

Each access is a burst of one word. The read latency is chosen at run time between 2 and 3 clocks, and the choice is fixed when the mode word is loaded during start-up.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: After reset only NOP is driven for PWR_US x CLK_MHZ cycles. Then come a precharge of all banks (A10=1), at least INIT_REFS auto refreshes, and one mode load. `init_done` and `req_ready` stay low until the mode load has been issued.
- R2: Commands are driven from registers as {cs_n,ras_n,cas_n,we_n}: NOP=0111, activate=0011, read=0101, write=0100, precharge=0010, refresh=0001, mode load=0000. The bank goes on `sd_ba` and the row goes on `sd_addr` with activate.
- R3: The mode word has A2:0=000 (one-word burst), A3=0 and A6:4 = 010 when `cas_lat3`=0 or 011 when `cas_lat3`=1. `cas_lat3` is sampled only when the mode word is issued, and later changes have no effect on read timing.
- R4: For each read, `rd_valid` pulses exactly once, CL+1 cycles after the read command is first driven on the pins. `rd_data` is then `sd_dq_in` as it stood CL cycles after the memory sampled the read.
- R5: A write drives `sd_dq_out` with `sd_dq_oe`=1 in the same cycle as the command. `sd_dqm_hi`=`req_wmask[1]` blocks DQ15:8 and `sd_dqm_lo`=`req_wmask[0]` blocks DQ7:0 (1 = byte not written). The masks are 0 during reads.
- R6: On read and write, A8:0 carries the column and A10 carries `req_autopre`. With A10=1 the bank is treated as closed afterwards.
- R7: One open-row register is kept per bank. On a row hit the read or write is issued with no activate. If a different row is open, that bank alone is precharged (A10=0) and then activated. A closed bank is activated directly.
- R8: At least T_RCD cycles separate an activate from a read or write to that bank. At least T_RP cycles separate a precharge from the next activate. At least T_RC cycles separate a refresh from the next command.
- R9: A refresh becomes owed every CLK_MHZ x REF_NS / 1000 cycles. At idle, an owed refresh is served before any user request: open banks are precharged together first, and `req_ready` stays low while a refresh is owed.
- R10: A request is accepted only on a cycle with `req_valid` and `req_ready` both high. Every accepted read yields exactly one word, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cas_lat3 | input | 1 | 1 selects read latency 3, 0 selects 2 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | 2 | Bank |
| req_row | input | 12 | Row |
| req_col | input | 9 | Column |
| req_autopre | input | 1 | Close the row after the access |
| req_wdata | input | 16 | Write data |
| req_wmask | input | 2 | Byte mask, bit1 upper, 1 = skip byte |
| rd_valid | output | 1 | Read word valid (one cycle) |
| rd_data | output | 16 | Read word |
| init_done | output | 1 | Start-up sequence complete |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Address bus |
| sd_dqm_hi | output | 1 | Upper byte mask |
| sd_dqm_lo | output | 1 | Lower byte mask |
| sd_dq_out | output | 16 | Write data to memory |
| sd_dq_oe | output | 1 | Drive enable for data bus |
| sd_dq_in | input | 16 | Data from memory |

## Verification
A refresh can fall due in the same cycle that a user request is waiting at idle. The refresh must win, any open rows must be closed first, and the request must then go ahead with its row reopened. The bench uses a short refresh interval and a dense stream of requests, so this collision happens many times per run. It counts refreshes that appear on the pins while a request is held pending. A cycle-level memory model judges each collision: it flags any activate to an open bank and any access to a closed bank, it flags refresh gaps beyond a bound, and it returns data that is compared word by word against a shadow copy kept by the bench.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int BA_W   = 2;
  localparam int NBANK  = 1 << BA_W;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 9;
  localparam int DQ_W   = 16;
  localparam int AP_BIT = 10;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    C_MRS = 4'b0000,
    C_REF = 4'b0001,
    C_PRE = 4'b0010,
    C_ACT = 4'b0011,
    C_WR  = 4'b0100,
    C_RD  = 4'b0101,
    C_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT, ST_IPRE, ST_IREF, ST_MRS, ST_IDLE
  } st_e;
endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(INTERVAL + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= CW'(INTERVAL - 1);
      pend <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= CW'(INTERVAL - 1);
      pend <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
      if (ack) pend <= 1'b0;
    end
  end

  // R9: a refresh is only acknowledged when one is owed
  assert_ack_when_owed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> pend);
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cl3,
  input  logic          issue,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [2:0] pipe;
  logic       tap;

  assign tap = cl3 ? pipe[2] : pipe[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe     <= {pipe[1:0], issue};
      rd_valid <= tap;
      if (tap) rd_data <= dq_in;
    end
  end

  assert_lat3_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cl3) |-> $past(issue, 4));
  assert_lat2_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !cl3) |-> $past(issue, 3));
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl import sdram_seq_pkg::*; #(
  parameter int CLK_MHZ   = 100,
  parameter int REF_NS    = 15625,
  parameter int PWR_US    = 200,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_MRD     = 2,
  parameter int INIT_REFS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cas_lat3,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_autopre,
  input  logic [DQ_W-1:0]  req_wdata,
  input  logic [1:0]       req_wmask,
  output logic             rd_valid,
  output logic [DQ_W-1:0]  rd_data,
  output logic             init_done,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_addr,
  output logic             sd_dqm_hi,
  output logic             sd_dqm_lo,
  output logic [DQ_W-1:0]  sd_dq_out,
  output logic             sd_dq_oe,
  input  logic [DQ_W-1:0]  sd_dq_in
);
  localparam int PWR_CYC = CLK_MHZ * PWR_US;
  localparam int REF_CYC = CLK_MHZ * REF_NS / 1000;
  localparam int T_RW    = 4;               // covers read latency plus bus turnaround
  localparam int WCW     = $clog2(PWR_CYC + 2);
  localparam int IRW     = $clog2(INIT_REFS + 1);

  st_e              st, ret;
  logic [WCW-1:0]   wcnt;
  logic [IRW-1:0]   nref;
  cmd_e             cmd_q;
  logic             rd_q, cl_q, done_q;
  logic [NBANK-1:0] open_v;
  logic [ROW_W-1:0] open_row [NBANK];
  logic             ref_pend, hit, in_idle;
  logic             go_pall, go_ref, go_rw, go_pre, go_act;

  // open-row table, one entry per bank
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = (req_bank == BA_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_v[b]   <= 1'b0;
        open_row[b] <= '0;
      end else if (go_pall || (sel && (go_pre || (go_rw && req_autopre)))) begin
        open_v[b] <= 1'b0;
      end else if (sel && go_act) begin
        open_v[b]   <= 1'b1;
        open_row[b] <= req_row;
      end
    end
  end

  always_comb begin
    in_idle   = (st == ST_IDLE);
    hit       = open_v[req_bank] && (open_row[req_bank] == req_row);
    req_ready = in_idle && !ref_pend && hit;
    go_pall   = in_idle && ref_pend && (|open_v);
    go_ref    = in_idle && ref_pend && !(|open_v);
    go_rw     = req_ready && req_valid;
    go_pre    = in_idle && !ref_pend && req_valid && !hit && open_v[req_bank];
    go_act    = in_idle && !ref_pend && req_valid && !open_v[req_bank];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_WAIT; ret <= ST_IPRE; wcnt <= WCW'(PWR_CYC - 1); nref <= '0;
      cmd_q <= C_NOP; sd_ba <= '0; sd_addr <= '0; sd_dq_out <= '0;
      sd_dq_oe <= 1'b0; {sd_dqm_hi, sd_dqm_lo} <= 2'b00;
      rd_q <= 1'b0; cl_q <= 1'b0; done_q <= 1'b0;
    end else begin
      cmd_q <= C_NOP; sd_dq_oe <= 1'b0; rd_q <= 1'b0;
      {sd_dqm_hi, sd_dqm_lo} <= 2'b00;
      unique case (st)
        ST_WAIT: if (wcnt == '0) st <= ret; else wcnt <= wcnt - 1'b1;
        ST_IPRE: begin
          cmd_q <= C_PRE; sd_addr <= '0; sd_addr[AP_BIT] <= 1'b1;
          st <= ST_WAIT; wcnt <= WCW'(T_RP - 1); ret <= ST_IREF;
        end
        ST_IREF: begin
          cmd_q <= C_REF; nref <= nref + 1'b1;
          st <= ST_WAIT; wcnt <= WCW'(T_RC - 1);
          ret <= (nref == IRW'(INIT_REFS - 1)) ? ST_MRS : ST_IREF;
        end
        ST_MRS: begin
          cmd_q <= C_MRS; sd_ba <= '0; sd_addr <= '0;
          sd_addr[6:4] <= cas_lat3 ? 3'd3 : 3'd2;
          cl_q <= cas_lat3; done_q <= 1'b1;
          st <= ST_WAIT; wcnt <= WCW'(T_MRD - 1); ret <= ST_IDLE;
        end
        ST_IDLE: begin
          if (go_pall) begin
            cmd_q <= C_PRE; sd_addr <= '0; sd_addr[AP_BIT] <= 1'b1;
            st <= ST_WAIT; wcnt <= WCW'(T_RP - 1); ret <= ST_IDLE;
          end else if (go_ref) begin
            cmd_q <= C_REF;
            st <= ST_WAIT; wcnt <= WCW'(T_RC - 1); ret <= ST_IDLE;
          end else if (go_rw) begin
            cmd_q <= req_write ? C_WR : C_RD;
            sd_ba <= req_bank; sd_addr <= '0;
            sd_addr[COL_W-1:0] <= req_col; sd_addr[AP_BIT] <= req_autopre;
            sd_dq_out <= req_wdata; sd_dq_oe <= req_write;
            {sd_dqm_hi, sd_dqm_lo} <= req_write ? req_wmask : 2'b00;
            rd_q <= !req_write;
            st <= ST_WAIT; ret <= ST_IDLE;
            wcnt <= req_autopre ? WCW'(T_RW + T_RP - 1) : WCW'(T_RW - 1);
          end else if (go_pre) begin
            cmd_q <= C_PRE; sd_ba <= req_bank; sd_addr <= '0;
            st <= ST_WAIT; wcnt <= WCW'(T_RP - 1); ret <= ST_IDLE;
          end else if (go_act) begin
            cmd_q <= C_ACT; sd_ba <= req_bank; sd_addr <= req_row;
            st <= ST_WAIT; wcnt <= WCW'(T_RCD - 1); ret <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign init_done = done_q;

  sdram_ref_timer #(.INTERVAL(REF_CYC)) u_ref (
    .clk(clk), .rst_n(rst_n), .ack(go_ref), .pend(ref_pend));

  sdram_rd_capture #(.DW(DQ_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cl3(cl_q), .issue(rd_q),
    .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data));

  // spacing monitors (T_RCD, T_RP < 15 assumed)
  logic [3:0] since_act, since_pre;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 4'hF; since_pre <= 4'hF;
    end else begin
      if (cmd_q == C_ACT) since_act <= 4'd1;
      else if (since_act != 4'hF) since_act <= since_act + 1'b1;
      if (cmd_q == C_PRE) since_pre <= 4'd1;
      else if (since_pre != 4'hF) since_pre <= since_pre + 1'b1;
    end
  end

  assert_act_to_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD || cmd_q == C_WR) |-> (since_act >= 4'(T_RCD)));
  assert_pre_to_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_ACT) |-> (since_pre >= 4'(T_RP)));
  assert_ready_after_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done);
  assert_refresh_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);
  assert_no_open_at_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_REF) |-> (open_v == '0));
endmodule

// File: tb/sim_sdram_seq_ctrl.sv
module sim_sdram_seq_ctrl;
  localparam int PERIOD  = 10;
  localparam int CLK_MHZ = 10;
  localparam int PWR_CYC = CLK_MHZ * 200;
  localparam int REF_CYC = CLK_MHZ * 15625 / 1000;
  localparam int T_RCD = 3, T_RP = 3, T_RC = 9;

  logic clk = 0, rst_n = 0, cas_lat3 = 0;
  logic req_valid = 0, req_write = 0, req_autopre = 0;
  logic [1:0] req_bank = 0, req_wmask = 0;
  logic [11:0] req_row = 0;
  logic [8:0] req_col = 0;
  logic [15:0] req_wdata = 0;
  logic req_ready, rd_valid, init_done;
  logic [15:0] rd_data;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm_hi, sd_dqm_lo, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;
  logic [15:0] sd_dq_out, sd_dq_in;

  always #(PERIOD/2) clk = ~clk;

  sdram_seq_ctrl #(.CLK_MHZ(CLK_MHZ), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC)) u0 (
    .clk, .rst_n, .cas_lat3, .req_valid, .req_ready, .req_write, .req_bank,
    .req_row, .req_col, .req_autopre, .req_wdata, .req_wmask, .rd_valid, .rd_data,
    .init_done, .sd_cs_n, .sd_ras_n, .sd_cas_n, .sd_we_n, .sd_ba, .sd_addr,
    .sd_dqm_hi, .sd_dqm_lo, .sd_dq_out, .sd_dq_oe, .sd_dq_in);

  int n_tests = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  function automatic int key(int b, int r, int c);
    return (b << 21) | (r << 9) | c;
  endfunction

  // ---------------- cycle-level memory model ----------------
  logic [15:0] mem [int];
  logic [3:0]  m_open;
  logic [11:0] m_row [4];
  int act_cyc [4];
  int cyc, m_cl, refs_init, first_cmd, last_ref, max_gap, collide, proto_err;
  bit m_mrs, pall_seen;
  logic [3:0] sv;
  logic [15:0] sd [4];

  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      m_open = 0; m_cl = 0; refs_init = 0; first_cmd = -1; last_ref = -1;
      max_gap = 0; collide = 0; proto_err = 0; m_mrs = 0; pall_seen = 0; cyc = 0;
      sv = 0; sd_dq_in = 16'hDEAD;
    end else begin
      logic [3:0] cmd;
      int k;
      cyc++;
      for (int i = 0; i < 3; i++) begin sv[i] = sv[i+1]; sd[i] = sd[i+1]; end
      sv[3] = 0;
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (cmd != 4'b0111 && first_cmd < 0) first_cmd = cyc;
      k = key(sd_ba, int'(m_row[sd_ba]), int'(sd_addr[8:0]));
      case (cmd)
        4'b0000: begin m_mrs = 1; m_cl = int'(sd_addr[6:4]); end
        4'b0001: begin
          if (m_open != 0) proto_err++;
          if (!m_mrs) refs_init++;
          else begin
            if (last_ref >= 0 && cyc - last_ref > max_gap) max_gap = cyc - last_ref;
            last_ref = cyc;
            if (req_valid) collide++;
          end
        end
        4'b0010: if (sd_addr[10]) begin m_open = 0; pall_seen = 1; end
                 else m_open[sd_ba] = 0;
        4'b0011: begin
          if (!m_mrs || m_open[sd_ba]) proto_err++;
          m_open[sd_ba] = 1; m_row[sd_ba] = sd_addr; act_cyc[sd_ba] = cyc;
        end
        4'b0100, 4'b0101: begin
          if (!m_open[sd_ba] || cyc - act_cyc[sd_ba] < T_RCD) proto_err++;
          if (cmd == 4'b0100) begin
            logic [15:0] old;
            old = mem.exists(k) ? mem[k] : 16'h0;
            if (!sd_dq_oe) proto_err++;
            if (!sd_dqm_hi) old[15:8] = sd_dq_out[15:8];
            if (!sd_dqm_lo) old[7:0]  = sd_dq_out[7:0];
            mem[k] = old;
          end else if (m_cl >= 2 && m_cl <= 3) begin
            sv[m_cl] = 1; sd[m_cl] = mem.exists(k) ? mem[k] : 16'h0;
          end
          if (sd_addr[10]) m_open[sd_ba] = 0;
        end
        default: ;
      endcase
      sd_dq_in = sv[0] ? sd[0] : 16'hDEAD;
    end
  end

  // ---------------- read stream collection ----------------
  logic [15:0] got_q[$], exp_q[$];
  logic [15:0] shadow [int];
  always @(negedge clk) if (rd_valid) got_q.push_back(rd_data);

  task automatic do_req(bit wr, int b, int r, int c, bit ap, logic [15:0] d, logic [1:0] m);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bank = 2'(b); req_row = 12'(r);
    req_col = 9'(c); req_autopre = ap; req_wdata = d; req_wmask = m;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (wr) begin
      logic [15:0] old;
      old = shadow.exists(key(b, r, c)) ? shadow[key(b, r, c)] : 16'h0;
      if (!m[1]) old[15:8] = d[15:8];
      if (!m[0]) old[7:0]  = d[7:0];
      shadow[key(b, r, c)] = old;
    end else
      exp_q.push_back(shadow.exists(key(b, r, c)) ? shadow[key(b, r, c)] : 16'h0);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic run_phase(bit cl3);
    int rows[3] = '{0, 1, 4095};
    int cols[3] = '{0, 7, 511};
    rst_n = 0; cas_lat3 = cl3;
    mem.delete(); shadow.delete(); got_q.delete(); exp_q.delete();
    repeat (4) @(negedge clk);
    // R1/R2 reset state
    chk(init_done == 0 && req_ready == 0 && rd_valid == 0, "R1 reset outputs", int'(init_done), 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R2 NOP in reset",
        int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    rst_n = 1;
    while (!init_done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(first_cmd >= PWR_CYC, "R1 power-up quiet time", first_cmd, PWR_CYC);
    chk(pall_seen && refs_init >= 2, "R1 precharge-all and init refreshes", refs_init, 2);
    chk(m_cl == (cl3 ? 3 : 2), "R3 mode latency field", m_cl, cl3 ? 3 : 2);
    cas_lat3 = !cl3;   // R3: must now be ignored
    // full writes, autoprecharge on one column (R5, R6, R7)
    foreach (rows[ri]) for (int b = 0; b < 4; b++) foreach (cols[ci])
      do_req(1, b, rows[ri], cols[ci], cols[ci] == 7,
             16'(b * 16'h1111 ^ rows[ri] * 7 ^ cols[ci] * 13 ^ (cl3 ? 16'h5A00 : 0)), 2'b00);
    // masked overwrites, all four mask values (R5)
    for (int b = 0; b < 4; b++) foreach (rows[ri]) foreach (cols[ci])
      do_req(1, b, rows[ri], cols[ci], 1'b0,
             ~16'(b * 16'h0F0F ^ rows[ri] ^ cols[ci] * 3), 2'((b + ci) % 4));
    // reads back with row hits and misses (R4, R7, R10)
    for (int b = 0; b < 4; b++) foreach (rows[ri]) foreach (cols[ci])
      do_req(0, b, rows[ri], cols[ci], rows[ri] == 1, 16'h0, 2'b00);
    repeat (20) @(negedge clk);
    chk(got_q.size() == exp_q.size(), "R10 read word count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] === exp_q[i], cl3 ? "R4 R5 read data CL3" : "R4 R5 read data CL2",
          int'(got_q[i]), int'(exp_q[i]));
    chk(proto_err == 0, "R7 R8 command legality", proto_err, 0);
    chk(max_gap > 0 && max_gap <= REF_CYC + 24, "R9 refresh gap bound", max_gap, REF_CYC);
    chk(collide > 0, "R9 refresh wins over pending request", collide, 1);
  endtask

  initial begin
    run_phase(1'b0);
    run_phase(1'b1);
    finish_run();
  end
endmodule